// File: doc/BRIEF.md
# Dual-Enable Byte-Wide SRAM Slave Front-End

This block models a byte-wide asynchronous static-RAM slave inside a clocked design. Every external pin is sampled on a fast internal clock. The pins are two enables of opposite polarity, a write strobe, an output enable, the address and the data in. Each pin passes through a two-flop synchronizer. The block then decodes the synchronized pins into one of four bus modes: deselected, output-off, read and write.

The block does not drive a tri-state pad itself. It presents the data bus as three signals: a separate data input, a data output and an output-enable flag. A pad cell outside the block combines them.

The backing store is parameterized. At the full-size setting (`ADDR_W = 13`) it holds 8192 bytes. A write is not committed while the strobe is low. It is committed once, at the moment the overlap of "selected" and "write strobe low" ends, whichever of the two ends first. There is no busy or ready signal, so any access may follow a write at once.

Top module: `sramFrontEnd`

## Requirements
- R1: The block is selected only when `selN` is 0 and `selP` is 1. With any other enable combination, `dataOe` stays 0 and no byte of the store changes, whatever `wrN`, `oeN`, `addr` and `dataIn` do.
- R2: Read mode is selected with `wrN`=1 and `oeN`=0. In this mode `dataOe` is 1 and `dataOut` carries the stored byte at `addr`.
- R3: Output-off mode is selected with `wrN`=1 and `oeN`=1. In this mode `dataOe` is 0.
- R4: A write window opens when the later of "selected" and "`wrN`=0" becomes true, and closes when the earlier of them becomes false. Exactly one byte is committed per window. This holds whether the window is closed by `wrN` rising, by `selN` rising or by `selP` falling.
- R5: The committed address and data are the last values sampled while the window was still open. Data that changes earlier inside the window has no effect.
- R6: While selected, `wrN`=0 forces `dataOe` to 0 even when `oeN`=0.
- R7: After reset, every byte of the store reads as 8'hFF until it is written.
- R8: A read immediately after a write to the same address returns the new byte. This includes a read whose mode begins in the same cycle as the commit.
- R9: A pin change reaches `dataOe` and `dataOut` after exactly three rising clock edges: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low chip enable |
| selP | input | 1 | Active-high chip enable |
| wrN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Data bus, input side |
| dataOut | output | DATA_W | Data bus, output side |
| dataOe | output | 1 | Output-enable flag for the data pad |

## Verification
The bench closes write windows in three ways: with the write strobe, with the low enable and with the high enable. A design that committed on the strobe edge alone would lose the bytes written in the two enable-ended cases.

The bench also changes the data while a window is open. A design that latched the data at the opening edge would read back the stale byte.

Two corner cases check the output enable. A strobe driven low during an active read must blank the output; a design that decoded only the output enable would keep driving. The read that begins in the very cycle of the commit must see the new byte; a design without forwarding would return the old one.

Strobe pulses given under each non-selecting enable pair must leave the store untouched. Never-written bytes must read all ones. A design with one pipeline stage too many or too few is caught by sampling exactly at the third edge.

// File: rtl/sramFePkg.sv
package sramFePkg;

  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0,
    MODE_OFF   = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } busMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic read;     // selected, strobe high, output enabled
    logic capture;  // write window open this cycle
    logic commit;   // write window closed this cycle
  } strobes_t;

endpackage

// File: rtl/sramFeSync.sv
module sramFeSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] async,
  output logic [WIDTH-1:0] synced
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RESET_VAL;
    else       stage[0] <= async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= RESET_VAL;
      else       stage[g] <= stage[g-1];
    end
  end

  assign synced = stage[STAGES-1];

endmodule

// File: rtl/sramFeCtrl.sv
module sramFeCtrl
  import sramFePkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     selNS,
  input  logic     selPS,
  input  logic     wrNS,
  input  logic     oeNS,
  output strobes_t str,
  output logic     dataOe
);

  busMode_e mode;
  logic     selected;
  logic     window;
  logic     windowQ;

  always_comb begin
    selected = !selNS && selPS;
    if (!selected)   mode = MODE_DESEL;
    else if (!wrNS)  mode = MODE_WRITE;
    else if (!oeNS)  mode = MODE_READ;
    else             mode = MODE_OFF;
  end

  assign window = (mode == MODE_WRITE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) windowQ <= 1'b0;
    else       windowQ <= window;
  end

  always_comb begin
    str.read    = (mode == MODE_READ);
    str.capture = window;
    str.commit  = windowQ && !window;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOe <= 1'b0;
    else       dataOe <= str.read;
  end

  // R1: deselected pins never lead to a driven bus
  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !selected |=> !dataOe);

  // R3: output-off mode keeps the bus released
  assert_off_released_R3: assert property (@(posedge clk) disable iff (!rstN)
    (selected && wrNS && oeNS) |=> !dataOe);

  // R6: strobe low blanks the output even with output enable low
  assert_wr_blanks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !wrNS) |=> !dataOe);

  // R4: a window produces a single commit
  assert_single_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    str.commit |=> !str.commit);

  // R4: no commit while the window is still open
  assert_commit_closed_R4: assert property (@(posedge clk) disable iff (!rstN)
    str.commit |-> !(selected && !wrNS));

endmodule

// File: rtl/sramFeData.sv
module sramFeData
  import sramFePkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          str,
  input  logic [ADDR_W-1:0] addrS,
  input  logic [DATA_W-1:0] dataS,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;
  logic              bypass;

  // last sample taken while the window is open
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
    end else if (str.capture) begin
      capAddr <= addrS;
      capData <= dataS;
    end
  end

  always_ff @(posedge clk) begin
    if (str.commit) mem[capAddr] <= capData;
  end

  // unwritten bytes read as all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           written <= '0;
    else if (str.commit) written[capAddr] <= 1'b1;
  end

  assign bypass = str.commit && (capAddr == addrS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOut <= '1;
    else if (str.read) begin
      if (bypass)                dataOut <= capData;
      else if (written[addrS])   dataOut <= mem[addrS];
      else                       dataOut <= '1;
    end
  end

  // R8: a read during the commit cycle sees the committed byte
  assert_fwd_new_R8: assert property (@(posedge clk) disable iff (!rstN)
    (str.read && bypass) |=> dataOut == $past(capData));

  // R7: a never-written byte reads all ones
  assert_fresh_ones_R7: assert property (@(posedge clk) disable iff (!rstN)
    (str.read && !bypass && !written[addrS]) |=> dataOut == '1);

  // R5: the captured address and data hold steady once the window closes
  assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!str.capture && $past(!str.capture)) |-> ($stable(capAddr) && $stable(capData)));

endmodule

// File: rtl/sramFrontEnd.sv
module sramFrontEnd
  import sramFePkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              selP,
  input  logic              wrN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int CTRL_W = 4;
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1011; // {selN, selP, wrN, oeN}
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [CTRL_W-1:0] ctrlS;
  logic [BUS_W-1:0]  busS;
  strobes_t          str;

  sramFeSync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RESET_VAL(CTRL_IDLE)) i_ctrlSync (
    .clk(clk), .rstN(rstN), .async({selN, selP, wrN, oeN}), .synced(ctrlS)
  );

  sramFeSync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) i_busSync (
    .clk(clk), .rstN(rstN), .async({addr, dataIn}), .synced(busS)
  );

  sramFeCtrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .selNS(ctrlS[3]), .selPS(ctrlS[2]), .wrNS(ctrlS[1]), .oeNS(ctrlS[0]),
    .str(str), .dataOe(dataOe)
  );

  sramFeData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .str(str),
    .addrS(busS[BUS_W-1:DATA_W]), .dataS(busS[DATA_W-1:0]),
    .dataOut(dataOut)
  );

endmodule

// File: tb/test_sramFrontEnd.sv
`timescale 1ns/1ps
module test_sramFrontEnd;

  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, selP = 1'b0, wrN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic dataOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sramFrontEnd #(.ADDR_W(AW), .DATA_W(DW)) i_sramFrontEnd (
    .clk(clk), .rstN(rstN), .selN(selN), .selP(selP), .wrN(wrN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  // {selN, selP, wrN, oeN, addr, expOe, expData}
  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    {4'b1010, 11'd5,   1'b0, 8'h00},
    {4'b1110, 11'd5,   1'b0, 8'h00},
    {4'b0010, 11'd5,   1'b0, 8'h00},
    {4'b0110, 11'd5,   1'b1, 8'hA5},
    {4'b0110, 11'd6,   1'b1, 8'h3C},
    {4'b0110, 11'd7,   1'b1, 8'h96},
    {4'b0111, 11'd5,   1'b0, 8'h00},
    {4'b1011, 11'd5,   1'b0, 8'h00},
    {4'b0110, 11'd100, 1'b1, 8'hFF}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    selN = 1'b1; selP = 1'b0; wrN = 1'b1; oeN = 1'b1;
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    addr = a; selN = 1'b0; selP = 1'b1; wrN = 1'b1; oeN = 1'b0;
    tick(5);
    chk({tag, " oe"}, 32'(dataOe), 32'd1);
    chk({tag, " data"}, 32'(dataOut), 32'(exp));
    idle(); tick(4);
  endtask

  // endMode 0: strobe ends window, 1: low enable ends it, 2: high enable ends it
  task automatic writeByte(input logic [AW-1:0] a, input logic [DW-1:0] d, input int endMode);
    idle(); addr = a; dataIn = d; tick(1);
    if (endMode == 0) begin
      selN = 1'b0; selP = 1'b1; tick(4);
      wrN = 1'b0; tick(6);
      wrN = 1'b1; tick(4);
    end else if (endMode == 1) begin
      wrN = 1'b0; tick(4);
      selP = 1'b1; selN = 1'b0; tick(6);
      selN = 1'b1; tick(4);
    end else begin
      wrN = 1'b0; selN = 1'b0; tick(4);
      selP = 1'b1; tick(6);
      selP = 1'b0; tick(4);
    end
    idle(); tick(4);
  endtask

  initial begin
    #(4 * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(4);

    // reset state
    chk("R1 reset oe", 32'(dataOe), 32'd0);
    readCheck(11'd0, 8'hFF, "R7 fresh byte 0");
    readCheck(11'd2047, 8'hFF, "R7 fresh last byte");

    // three ways to close a window
    writeByte(11'd5, 8'hA5, 0);
    writeByte(11'd6, 8'h3C, 1);
    writeByte(11'd7, 8'h96, 2);

    // mode table walk
    for (int i = 0; i < NV; i++) begin
      {selN, selP, wrN, oeN} = VEC[i][23:20];
      addr = VEC[i][19:9];
      tick(5);
      chk($sformatf("R1 R2 R3 R4 row %0d oe", i), 32'(dataOe), 32'(VEC[i][8]));
      if (VEC[i][8]) chk($sformatf("R2 R4 row %0d data", i), 32'(dataOut), 32'(VEC[i][7:0]));
      idle(); tick(4);
    end

    // R1: strobe pulses under non-selecting enables change nothing
    addr = 11'd5; dataIn = 8'hEE;
    for (int k = 0; k < 3; k++) begin
      selN = (k != 1); selP = (k == 0); oeN = 1'b0; tick(2);
      wrN = 1'b0; tick(5);
      chk($sformatf("R1 desel %0d oe", k), 32'(dataOe), 32'd0);
      wrN = 1'b1; tick(4);
      idle(); tick(3);
    end
    readCheck(11'd5, 8'hA5, "R1 byte untouched");

    // R5: data changed inside the window; last value wins
    idle(); addr = 11'd9; dataIn = 8'h11; tick(1);
    selN = 1'b0; selP = 1'b1; tick(3);
    wrN = 1'b0; tick(4);
    dataIn = 8'h22; tick(5);
    wrN = 1'b1; tick(4);
    idle(); tick(3);
    readCheck(11'd9, 8'h22, "R5 last sample");

    // R6 + R8: strobe low during a read blanks the output, then read at once
    addr = 11'd8; dataIn = 8'h5A;
    selN = 1'b0; selP = 1'b1; wrN = 1'b1; oeN = 1'b0; tick(5);
    chk("R2 pre-read on", 32'(dataOe), 32'd1);
    chk("R7 pre-read ones", 32'(dataOut), 32'hFF);
    wrN = 1'b0; tick(5);
    chk("R6 strobe blanks oe", 32'(dataOe), 32'd0);
    wrN = 1'b1; tick(3);
    chk("R8 oe back on", 32'(dataOe), 32'd1);
    chk("R8 new byte at once", 32'(dataOut), 32'h5A);
    idle(); tick(4);

    // R9: latency of exactly three edges
    selN = 1'b0; selP = 1'b1; wrN = 1'b1; oeN = 1'b1; addr = 11'd6; tick(5);
    oeN = 1'b0; tick(2);
    chk("R9 not yet after two edges", 32'(dataOe), 32'd0);
    tick(1);
    chk("R9 on after three edges", 32'(dataOe), 32'd1);
    chk("R9 data after three edges", 32'(dataOut), 32'h3C);
    idle(); tick(4);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule